// File: doc/BRIEF.md
# Inter-Processor Software Interrupt Cause Unit

This unit lets any processor post software interrupts to any subset of processors. Each processor owns a 16-bit register of pending cause bits. Any bus port can raise one cause bit in several processors with a single word write to one of sixteen raise addresses. Software drops causes by writing ones to a processor's own cause address.

The cause bits of each processor fall into four groups of unequal size. Each group is OR-reduced to one signal. A shared 8-bit partition register routes each group onto one of three interrupt priority lines, or onto none of them. The resulting 3-bit field per processor goes to the interrupt distributor.

Several bus ports can write in the same cycle. A read port returns the cause and partition state.

Top module: `ipi_cause_unit`

## Requirements
- R1: After synchronous reset every cause register, the partition register and every output line are zero.
- R2: A write of data D to address 0x140+k (k in 0..15) sets cause bit k of every processor c with D[c]=1. All other cause bits keep their values.
- R3: Processors whose index is at or above `cpu_cnt` are never set by a raise write, whatever the data bit for them holds.
- R4: A write of data D to address 0x100+c, with c below `cpu_cnt`, clears the cause bits of processor c where D[15:0] is one and keeps the rest.
- R5: When one port raises a cause bit and another port clears the same bit in the same cycle, the bit ends up set.
- R6: Cause bits form the groups {0}, {1..3}, {4..7} and {8..15}. A group is active when any of its bits is set. With a partition value of zero, every active group drives line 0.
- R7: Partition field g sits at bits [2g+1:2g] and holds the line index (0, 1 or 2) that group g drives. Output bit i of a processor is the OR of its active groups mapped to i. A group mapped to 3 drives nothing.
- R8: A write to address 0x190 loads data bits [7:0] into the partition register and discards the upper bits. If several ports write it in the same cycle, the highest-numbered port wins.
- R9: The read port returns processor c's cause at 0x100+c, the partition value at 0x190, and zero at every other address.
- R10: A write changes state and outputs only at the clock edge that captures it. The outputs are combinational from the registers, so they reflect the write right after that edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_cnt | input | $clog2(N_CPU+1) | Number of processors present |
| wr_en | input | N_PORT | Write strobe per bus port |
| wr_addr | input | N_PORT*ADDR_W | Word address per port, port p in slice p |
| wr_data | input | N_PORT*DATA_W | Write data per port, port p in slice p |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data, combinational |
| irq_lines | output | N_CPU*3 | Three priority lines per processor, processor c in bits [3c+2:3c] |

## Verification
The bench runs a write sequence in which partition values drop one group and swap the line of another. A unit that ignores index 3, or that reverses the order of the fields, gives the wrong line pattern. One directed test issues a raise and a clear to the same bit in the same cycle; a unit that lets the clear win loses that bit. Other directed tests check that data bits for absent processors are ignored, that a partial clear keeps the other bits, that upper partition data bits are discarded and that the higher-numbered port wins a partition collision. These catch a unit that raises causes in missing processors or wipes whole registers.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int CAUSE_W   = 16;
    localparam int LINE_W    = 3;
    localparam int N_GROUP   = 4;
    localparam int FIELD_W   = 2;
    localparam int PART_W    = N_GROUP * FIELD_W;

    localparam int CLR_BASE  = 'h100;
    localparam int SET_BASE  = 'h140;
    localparam int PART_ADDR = 'h190;

    typedef logic [CAUSE_W-1:0] cause_t;
    typedef logic [PART_W-1:0]  part_t;
    typedef logic [LINE_W-1:0]  lines_t;
    typedef logic [N_GROUP-1:0] hits_t;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_RAISE,
        OP_DROP,
        OP_PART
    } wr_op_e;

    typedef struct packed {
        wr_op_e     op;
        logic [7:0] sel;
    } wr_kind_t;

    function automatic hits_t group_hits(cause_t c);
        hits_t h;
        h[0] = c[0];
        h[1] = |c[3:1];
        h[2] = |c[7:4];
        h[3] = |c[15:8];
        return h;
    endfunction

    function automatic lines_t route(hits_t h, part_t p);
        lines_t r;
        logic [3:0] shifted;
        r = '0;
        for (int g = 0; g < N_GROUP; g++) begin
            shifted = 4'(h[g]) << p[g*FIELD_W +: FIELD_W];
            r |= shifted[LINE_W-1:0];
        end
        return r;
    endfunction

endpackage

// File: rtl/ipi_wr_decode.sv
module ipi_wr_decode
    import ipi_pkg::*;
#(
    parameter int N_CPU  = 4,
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int CNT_W  = $clog2(N_CPU + 1)
) (
    input  logic                          en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             data,
    input  logic [CNT_W-1:0]              cpu_cnt,
    output logic [N_CPU-1:0][CAUSE_W-1:0] set_mat,
    output logic [N_CPU-1:0][CAUSE_W-1:0] clr_mat,
    output logic                          part_we,
    output part_t                         part_val
);

    wr_kind_t kind;
    int       a;

    always_comb begin
        a        = int'(addr);
        kind.op  = OP_NONE;
        kind.sel = '0;
        if (en) begin
            if (a >= SET_BASE && a < SET_BASE + CAUSE_W) begin
                kind.op  = OP_RAISE;
                kind.sel = 8'(a - SET_BASE);
            end else if (a >= CLR_BASE && a < CLR_BASE + N_CPU) begin
                kind.op  = OP_DROP;
                kind.sel = 8'(a - CLR_BASE);
            end else if (a == PART_ADDR) begin
                kind.op  = OP_PART;
            end
        end
    end

    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
        logic present;
        assign present = (c < int'(cpu_cnt));
        always_comb begin
            set_mat[c] = '0;
            clr_mat[c] = '0;
            if (present && kind.op == OP_RAISE && data[c])
                set_mat[c] = cause_t'(1) << kind.sel[3:0];
            if (present && kind.op == OP_DROP && int'(kind.sel) == c)
                clr_mat[c] = data[CAUSE_W-1:0];
        end
    end

    assign part_we  = (kind.op == OP_PART);
    assign part_val = data[PART_W-1:0];

endmodule

// File: rtl/ipi_cause_bank.sv
module ipi_cause_bank
    import ipi_pkg::*;
#(
    parameter int N_CPU = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [N_CPU-1:0][CAUSE_W-1:0] set_mask,
    input  logic [N_CPU-1:0][CAUSE_W-1:0] clr_mask,
    output logic [N_CPU-1:0][CAUSE_W-1:0] cause_q
);

    for (genvar c = 0; c < N_CPU; c++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                cause_q[c] <= '0;
            else
                cause_q[c] <= (cause_q[c] & ~clr_mask[c]) | set_mask[c];
        end
    end

endmodule

// File: rtl/ipi_partition_map.sv
module ipi_partition_map
    import ipi_pkg::*;
#(
    parameter int N_CPU = 4
) (
    input  logic [N_CPU-1:0][CAUSE_W-1:0] cause_q,
    input  part_t                         part_q,
    output logic [N_CPU*LINE_W-1:0]       lines
);

    for (genvar c = 0; c < N_CPU; c++) begin : g_map
        assign lines[c*LINE_W +: LINE_W] = route(group_hits(cause_q[c]), part_q);
    end

endmodule

// File: rtl/ipi_cause_unit.sv
module ipi_cause_unit
    import ipi_pkg::*;
#(
    parameter int N_CPU  = 4,
    parameter int N_PORT = 2,
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(N_CPU + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [CNT_W-1:0]           cpu_cnt,
    input  logic [N_PORT-1:0]          wr_en,
    input  logic [N_PORT*ADDR_W-1:0]   wr_addr,
    input  logic [N_PORT*DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    output logic [N_CPU*LINE_W-1:0]    irq_lines
);

    logic [N_PORT-1:0][N_CPU-1:0][CAUSE_W-1:0] p_set, p_clr;
    logic [N_PORT-1:0]                         p_part_we;
    part_t [N_PORT-1:0]                        p_part_val;

    logic [N_CPU-1:0][CAUSE_W-1:0] set_all, clr_all;
    logic [N_CPU-1:0][CAUSE_W-1:0] cause_q;
    part_t                         part_q, part_d;
    logic                          part_we;

    for (genvar p = 0; p < N_PORT; p++) begin : g_port
        ipi_wr_decode #(
            .N_CPU  (N_CPU),
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .CNT_W  (CNT_W)
        ) u_dec (
            .en       (wr_en[p]),
            .addr     (wr_addr[p*ADDR_W +: ADDR_W]),
            .data     (wr_data[p*DATA_W +: DATA_W]),
            .cpu_cnt  (cpu_cnt),
            .set_mat  (p_set[p]),
            .clr_mat  (p_clr[p]),
            .part_we  (p_part_we[p]),
            .part_val (p_part_val[p])
        );
    end

    always_comb begin
        set_all = '0;
        clr_all = '0;
        part_we = 1'b0;
        part_d  = part_q;
        for (int p = 0; p < N_PORT; p++) begin
            set_all |= p_set[p];
            clr_all |= p_clr[p];
            if (p_part_we[p]) begin
                part_we = 1'b1;
                part_d  = p_part_val[p];
            end
        end
    end

    ipi_cause_bank #(.N_CPU(N_CPU)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .set_mask (set_all),
        .clr_mask (clr_all),
        .cause_q  (cause_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            part_q <= '0;
        else if (part_we)
            part_q <= part_d;
    end

    ipi_partition_map #(.N_CPU(N_CPU)) u_map (
        .cause_q (cause_q),
        .part_q  (part_q),
        .lines   (irq_lines)
    );

    always_comb begin
        int ra;
        ra      = int'(rd_addr);
        rd_data = '0;
        if (ra >= CLR_BASE && ra < CLR_BASE + N_CPU)
            rd_data = DATA_W'(cause_q[ra - CLR_BASE]);
        else if (ra == PART_ADDR)
            rd_data = DATA_W'(part_q);
    end

endmodule

module ipi_cause_unit_chk
    import ipi_pkg::*;
#(
    parameter int N_CPU  = 4,
    parameter int N_PORT = 2,
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 3
) (
    input logic                          clk,
    input logic                          rst,
    input logic [CNT_W-1:0]              cpu_cnt,
    input logic [N_PORT-1:0]             wr_en,
    input logic [N_PORT*ADDR_W-1:0]      wr_addr,
    input logic [N_PORT*DATA_W-1:0]      wr_data,
    input logic [N_CPU-1:0][CAUSE_W-1:0] cause_q,
    input part_t                         part_q,
    input logic [N_CPU*LINE_W-1:0]       irq_lines
);

    logic was_rst = 1'b0;
    always_ff @(posedge clk) was_rst <= rst;

    always_ff @(posedge clk) begin
        if (was_rst && !rst)
            a_r1_reset_clear: assert (cause_q == '0 && part_q == '0 && irq_lines == '0);
    end

    a_r2_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !(|wr_en) |=> $stable(cause_q) && $stable(part_q));

    a_r5_raise_lands: assert property (@(posedge clk) disable iff (rst)
        (wr_en[0] && int'(wr_addr[ADDR_W-1:0]) >= SET_BASE
                  && int'(wr_addr[ADDR_W-1:0]) < SET_BASE + CAUSE_W
                  && wr_data[0] && cpu_cnt != '0)
        |=> cause_q[0][$past(wr_addr[3:0])]);

    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        cause_q[0] == '0 |-> irq_lines[LINE_W-1:0] == '0);

    a_r7_all_dropped: assert property (@(posedge clk) disable iff (rst)
        part_q == '1 |-> irq_lines == '0);

    for (genvar c = 0; c < N_CPU; c++) begin : g_absent
        a_r3_absent_stays_clear: assert property (@(posedge clk) disable iff (rst)
            (c >= int'(cpu_cnt) && cause_q[c] == '0) |=> cause_q[c] == '0);
    end

endmodule

bind ipi_cause_unit ipi_cause_unit_chk #(
    .N_CPU  (N_CPU),
    .N_PORT (N_PORT),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_cnt   (cpu_cnt),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cause_q   (cause_q),
    .part_q    (part_q),
    .irq_lines (irq_lines)
);

// File: tb/test_ipi_cause_unit.sv
module test_ipi_cause_unit;

    localparam int NC = 4;
    localparam int NP = 2;
    localparam int AW = 10;
    localparam int DW = 32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [2:0]       cpu_cnt = 3'd3;
    logic [NP-1:0]    wr_en = '0;
    logic [NP*AW-1:0] wr_addr = '0;
    logic [NP*DW-1:0] wr_data = '0;
    logic [AW-1:0]    rd_addr = '0;
    logic [DW-1:0]    rd_data;
    logic [NC*3-1:0]  irq_lines;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ipi_cause_unit #(.N_CPU(NC), .N_PORT(NP), .ADDR_W(AW), .DATA_W(DW)) i_ipi_cause_unit (
        .clk(clk), .rst(rst), .cpu_cnt(cpu_cnt), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_lines(irq_lines)
    );

    typedef struct packed {
        logic [9:0]  addr;
        logic [31:0] data;
        logic [2:0]  e0;
        logic [2:0]  e1;
    } vec_t;

    // Port 0 writes; expected lines of processors 0 and 1 after each write (R2 R4 R6 R7)
    localparam vec_t TV [11] = '{
        '{10'h140, 32'h0000_0001, 3'b001, 3'b000},
        '{10'h145, 32'h0000_0002, 3'b001, 3'b001},
        '{10'h190, 32'h0000_00C6, 3'b100, 3'b001},
        '{10'h14A, 32'h0000_0003, 3'b100, 3'b001},
        '{10'h142, 32'h0000_0002, 3'b100, 3'b011},
        '{10'h100, 32'h0000_0001, 3'b000, 3'b011},
        '{10'h101, 32'h0000_0020, 3'b000, 3'b010},
        '{10'h190, 32'h0000_00E4, 3'b000, 3'b010},
        '{10'h190, 32'h0000_0000, 3'b001, 3'b001},
        '{10'h100, 32'h0000_FFFF, 3'b000, 3'b001},
        '{10'h101, 32'h0000_FFFF, 3'b000, 3'b000}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(int p, logic [AW-1:0] a, logic [DW-1:0] d);
        wr_en[p]             = 1'b1;
        wr_addr[p*AW +: AW]  = a;
        wr_data[p*DW +: DW]  = d;
    endtask

    task automatic wr(int p, logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        wr_en = '0;
        put(p, a, d);
        @(negedge clk);
        wr_en = '0;
        #1;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    function automatic logic [2:0] line_of(int c);
        return irq_lines[c*3 +: 3];
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1: everything zero after reset
        chk("R1 lines", 32'(irq_lines), 32'h0);
        rd(10'h100, v); chk("R1 cause0", v, 32'h0);
        rd(10'h190, v); chk("R1 partition", v, 32'h0);

        for (int i = 0; i < 11; i++) begin
            wr(0, TV[i].addr, TV[i].data);
            chk($sformatf("R7 vec%0d cpu0", i), 32'(line_of(0)), 32'(TV[i].e0));
            chk($sformatf("R6 vec%0d cpu1", i), 32'(line_of(1)), 32'(TV[i].e1));
        end

        // R10: no change before the capturing edge, change right after it
        @(negedge clk);
        put(0, 10'h140, 32'h1);
        #1;
        chk("R10 before edge", 32'(line_of(0)), 32'h0);
        @(negedge clk);
        wr_en = '0;
        #1;
        chk("R10 after edge", 32'(line_of(0)), 32'h1);

        // R3: data bit for processor 3 ignored with cpu_cnt=3
        wr(0, 10'h143, 32'hF);
        chk("R3 cpu3 lines", 32'(line_of(3)), 32'h0);
        rd(10'h103, v); chk("R3 cpu3 cause", v, 32'h0);
        rd(10'h102, v); chk("R2 cpu2 cause", v, 32'h0008);

        // R4: partial clear keeps other bits
        wr(0, 10'h100, 32'h0001);
        rd(10'h100, v); chk("R4 partial clear", v, 32'h0008);

        // R5: raise and clear of same bit in one cycle
        @(negedge clk);
        wr_en = '0;
        put(0, 10'h100, 32'hFFFF);
        put(1, 10'h147, 32'h1);
        @(negedge clk);
        wr_en = '0;
        #1;
        rd(10'h100, v); chk("R5 raise wins", v, 32'h0080);

        // R8: partition collision, higher port wins; upper bits discarded
        @(negedge clk);
        put(0, 10'h190, 32'h01);
        put(1, 10'h190, 32'h02);
        @(negedge clk);
        wr_en = '0;
        #1;
        rd(10'h190, v); chk("R8 collision", v, 32'h02);
        wr(0, 10'h190, 32'hFFFF_FF1B);
        rd(10'h190, v); chk("R8 width", v, 32'h1B);

        // R7: 0x1B maps g0->3 g1->2 g2->1 g3->0
        chk("R7 cpu0 g2 on line1", 32'(line_of(0)), 32'h2);
        chk("R7 cpu1 g1 on line2", 32'(line_of(1)), 32'h4);

        // R9: read decode
        rd(10'h180, v); chk("R9 unmapped", v, 32'h0);
        rd(10'h101, v); chk("R9 cpu1 cause", v, 32'h0008);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule